// File: doc/BRIEF.md
# One-Shot Sampler Record/Playback Controller

This block sequences a single-voice digital sampler that keeps its sound in an external parallel SRAM, takes samples from a parallel ADC and plays them back through a parallel DAC. A start request arms one pass through the buffer. The pass is either a recording pass, where every sample period writes the converter word into the SRAM, or a playback pass, where every period reads the SRAM out toward the DAC. When the last buffer address has been served, the pass ends by itself and the block waits for the next start.

The sample rate comes from a divide-by-N of the fast system clock. The same divisor input governs recording and playback, so playing a sound with a different N than it was recorded with shifts its pitch, with no interpolation. Each sample period places its memory strobe half a period after the address has settled, so the address and strobe never change together.

Top module: `oneshot_sampler_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `pass_done`, `sram_wr_stb` and `sram_rd_stb` are 0, `sram_addr` is 0, `adc_sel` is 0 and `dac_sel` is 1.
- R2: A high `start_req` seen at a rising clock edge while idle starts a pass at address 0; `busy` is 1 from that edge, and `rec_mode` at that edge picks the pass kind (1 = record, 0 = play).
- R3: Every sample period lasts N clocks, N being `div_ratio` with values below 2 taken as 2; N is captured at the start edge and recaptured at the last clock of each period, so a change of `div_ratio` applies from the next period boundary.
- R4: In clock offset floor(N/2) of a period (offsets counted from 0, the cycle after the start edge being offset 0 of the first period) exactly one strobe is high for one clock: `sram_wr_stb` in a record pass, `sram_rd_stb` in a play pass; both are never high together and neither is high while idle.
- R5: `sram_addr` holds the period index during the whole period and rises by one after the last clock of the period; after the period of address BUF_LEN-1 it returns to 0 and `busy` falls.
- R6: `pass_done` is high for exactly one clock, the first clock in which `busy` is 0 after a pass.
- R7: A `start_req` while busy is ignored, and changes of `rec_mode` during a pass have no effect: strobe kind, strobe timing and addresses continue unchanged.
- R8: `adc_sel` equals the mode latched at the last accepted start and `dac_sel` is its complement; both hold their values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to begin one pass |
| rec_mode | input | 1 | Pass kind sampled at start: 1 record, 0 play |
| div_ratio | input | DIV_W | Clocks per sample period |
| sram_addr | output | log2(BUF_LEN) | Buffer address |
| sram_wr_stb | output | 1 | One-clock write strobe (record pass) |
| sram_rd_stb | output | 1 | One-clock read strobe (play pass) |
| adc_sel | output | 1 | ADC chip select, high in record mode |
| dac_sel | output | 1 | DAC chip select, high in play mode |
| busy | output | 1 | A pass is running |
| pass_done | output | 1 | One-clock pulse at the end of a pass |

## Verification
Four passes are driven, and for each one the full list of expected strobes (cycle, address, kind) is predicted before the pass and matched as strobes appear. A record pass with an even divisor and a stray start plus a flipped mode mid-pass separates a correct run from one that restarts or changes kind; a play pass whose divisor changes after the start tells whether the new N is taken at the period boundary rather than immediately or never. An odd divisor checks the half-period strobe placement with rounding down, and a divisor of 1 checks the lower clamp, while the end of every pass checks the address wrap, the fall of `busy` and the single-cycle done pulse.

// File: rtl/smp_pkg.sv
package smp_pkg;

    // Control state of the pass sequencer.
    typedef struct packed {
        logic busy;
        logic rec;
        logic done;
    } smp_ctl_t;

    localparam int unsigned SMP_MIN_RATIO = 2;

endpackage

// File: rtl/smp_rate_div.sv
module smp_rate_div #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic             mid
);
    import smp_pkg::*;

    localparam logic [DIV_W-1:0] MIN_N = DIV_W'(SMP_MIN_RATIO);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] per;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] ratio_eff;

    always_comb begin
        ratio_eff = (ratio < MIN_N) ? MIN_N : ratio;
        tick      = run && (st_q.cnt == st_q.per - 1'b1);
        mid       = run && (st_q.cnt == (st_q.per >> 1));
        st_d      = st_q;
        if (restart) begin
            st_d.cnt = '0;
            st_d.per = ratio_eff;
        end else if (tick) begin
            // period boundary: new divisor applies here
            st_d.cnt = '0;
            st_d.per = ratio_eff;
        end else if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.per <= MIN_N;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smp_addr_seq.sv
module smp_addr_seq #(
    parameter int unsigned BUF_LEN = 16,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BUF_LEN - 1);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        wrap   = step && (addr_q == LAST);
        addr_d = addr_q;
        if (clear || wrap) begin
            addr_d = '0;
        end else if (step) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/oneshot_sampler_ctrl.sv
module oneshot_sampler_ctrl #(
    parameter int unsigned BUF_LEN = 16,
    parameter int unsigned DIV_W   = 16,
    localparam int unsigned ADDR_W = (BUF_LEN > 1) ? $clog2(BUF_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              rec_mode,
    input  logic [DIV_W-1:0]  div_ratio,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_wr_stb,
    output logic              sram_rd_stb,
    output logic              adc_sel,
    output logic              dac_sel,
    output logic              busy,
    output logic              pass_done
);
    import smp_pkg::*;

    smp_ctl_t ctl_d, ctl_q;
    logic     start_ok;
    logic     tick;
    logic     mid;
    logic     wrap;

    smp_rate_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_ok),
        .run     (ctl_q.busy),
        .ratio   (div_ratio),
        .tick    (tick),
        .mid     (mid)
    );

    smp_addr_seq #(
        .BUF_LEN (BUF_LEN),
        .ADDR_W  (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_ok),
        .step  (tick),
        .addr  (sram_addr),
        .wrap  (wrap)
    );

    always_comb begin
        start_ok   = start_req && !ctl_q.busy;
        ctl_d      = ctl_q;
        ctl_d.done = wrap;
        if (start_ok) begin
            ctl_d.busy = 1'b1;
            ctl_d.rec  = rec_mode;
        end else if (wrap) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sram_wr_stb = mid &&  ctl_q.rec;
    assign sram_rd_stb = mid && !ctl_q.rec;
    assign adc_sel     =  ctl_q.rec;
    assign dac_sel     = !ctl_q.rec;
    assign busy        = ctl_q.busy;
    assign pass_done   = ctl_q.done;

endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_wr_stb,
    input logic              sram_rd_stb,
    input logic              adc_sel,
    input logic              busy,
    input logic              pass_done
);

    // R4: never both strobes, never a strobe while idle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_wr_stb || sram_rd_stb) |-> (busy && !(sram_wr_stb && sram_rd_stb)));

    // R4 / R8: write strobe only in record mode, read strobe only in play mode
    p_kind_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_wr_stb |-> adc_sel) and (sram_rd_stb |-> !adc_sel));

    // R6: done marks the first idle cycle after a pass
    p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (!busy && $past(busy)));

    // R6: done lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R5: during a pass the address only moves up by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sram_addr != $past(sram_addr)))
            |-> (sram_addr == $past(sram_addr) + 1'b1));

    // R7: the mode cannot change while a pass runs
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(adc_sel));

    // R8: mode and address hold while idle without a start
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req) |=> ($stable(adc_sel) && $stable(sram_addr)));

endmodule

bind oneshot_sampler_ctrl smp_checker #(
    .ADDR_W (ADDR_W)
) u_smp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .sram_addr   (sram_addr),
    .sram_wr_stb (sram_wr_stb),
    .sram_rd_stb (sram_rd_stb),
    .adc_sel     (adc_sel),
    .busy        (busy),
    .pass_done   (pass_done)
);

// File: tb/tb_oneshot_sampler_ctrl.sv
module tb_oneshot_sampler_ctrl;

    localparam int unsigned BUF_LEN = 8;
    localparam int unsigned DIV_W   = 8;
    localparam int unsigned ADDR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic              rec_mode = 1'b0;
    logic [DIV_W-1:0]  div_ratio = 8'd4;
    logic [ADDR_W-1:0] sram_addr;
    logic              sram_wr_stb;
    logic              sram_rd_stb;
    logic              adc_sel;
    logic              dac_sel;
    logic              busy;
    logic              pass_done;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    typedef struct {
        int cyc;
        int addr;
        bit wr;
    } exp_t;

    exp_t expq[$];

    oneshot_sampler_ctrl #(
        .BUF_LEN (BUF_LEN),
        .DIV_W   (DIV_W)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .rec_mode    (rec_mode),
        .div_ratio   (div_ratio),
        .sram_addr   (sram_addr),
        .sram_wr_stb (sram_wr_stb),
        .sram_rd_stb (sram_rd_stb),
        .adc_sel     (adc_sel),
        .dac_sel     (dac_sel),
        .busy        (busy),
        .pass_done   (pass_done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: every strobe must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && (sram_wr_stb || sram_rd_stb)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4", "unexpected strobe at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cyc == e.cyc, "R3", "strobe cycle", cyc, e.cyc);
                check(int'(sram_addr) == e.addr, "R5", "strobe address",
                      int'(sram_addr), e.addr);
                check(sram_wr_stb == e.wr && sram_rd_stb == !e.wr, "R4",
                      "strobe kind (wr)", int'(sram_wr_stb), int'(e.wr));
            end
        end
    end

    function automatic int eff(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // Driver: start one pass, push its expected strobes, then check its end.
    task automatic run_pass(input bit rec, input int n0, input int n1, input bit poke);
        int c;
        int base;
        int done_c;
        @(negedge clk);
        div_ratio = DIV_W'(n0);
        rec_mode  = rec;
        start_req = 1'b1;
        c    = cyc;
        base = c + 1;
        for (int p = 0; p < int'(BUF_LEN); p++) begin
            int n;
            exp_t e;
            n = (p == 0) ? eff(n0) : eff(n1);
            e.cyc  = base + n / 2;
            e.addr = p;
            e.wr   = rec;
            expq.push_back(e);
            base += n;
        end
        done_c = base;
        @(negedge clk);
        start_req = 1'b0;
        div_ratio = DIV_W'(n1);
        rec_mode  = !rec;            // R7: ignored during the pass
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        check(int'(sram_addr) == 0, "R2", "first address", int'(sram_addr), 0);
        check(adc_sel == rec && dac_sel == !rec, "R8", "adc_sel in pass",
              int'(adc_sel), int'(rec));
        if (poke) begin
            while (cyc != c + 1 + eff(n0) + 1) @(negedge clk);
            start_req = 1'b1;        // R7: start while busy
            @(negedge clk);
            start_req = 1'b0;
            check(int'(sram_addr) == 1, "R7", "address after stray start",
                  int'(sram_addr), 1);
        end
        while (cyc != done_c - 1) @(negedge clk);
        check(busy == 1'b1 && pass_done == 1'b0, "R6", "busy before end",
              int'(busy), 1);
        @(negedge clk);
        check(pass_done == 1'b1, "R6", "done pulse", int'(pass_done), 1);
        check(busy == 1'b0, "R5", "busy cleared at end", int'(busy), 0);
        check(int'(sram_addr) == 0, "R5", "address wrapped", int'(sram_addr), 0);
        @(negedge clk);
        check(pass_done == 1'b0, "R6", "done single cycle", int'(pass_done), 0);
        check(adc_sel == rec && dac_sel == !rec, "R8", "selects hold idle",
              int'(adc_sel), int'(rec));
        check(expq.size() == 0, "R4", "strobes left over", expq.size(), 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && pass_done == 1'b0, "R1", "reset busy/done",
              int'(busy), 0);
        check(sram_wr_stb == 1'b0 && sram_rd_stb == 1'b0, "R1", "reset strobes",
              int'(sram_wr_stb), 0);
        check(int'(sram_addr) == 0, "R1", "reset address", int'(sram_addr), 0);
        check(adc_sel == 1'b0 && dac_sel == 1'b1, "R1", "reset selects",
              int'(dac_sel), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_pass(1'b1, 4, 4, 1'b1);  // R2 R7: record, stray start
        run_pass(1'b0, 4, 6, 1'b0);  // R3: divisor change at boundary
        run_pass(1'b0, 5, 5, 1'b0);  // R4: odd divisor
        run_pass(1'b1, 1, 0, 1'b0);  // R3: clamp to 2
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule